// File: doc/BRIEF.md
# Parallel flash command interpreter

This block behaves like a word-wide parallel NOR flash device that is driven by the classic write-command protocol. A host reaches it over a simple synchronous bus with a byte address, write data, read data, a read strobe and a write strobe. Behind the bus sits a small storage array. The array is divided into equal power-of-two sectors and comes out of reset filled with all ones.

Writes are interpreted as commands by a four-phase sequencer. The low byte of the write data is the command code. The phase and the latched command decide what a read returns: stored array words, the status byte, or one byte of the query table. One command erases a whole sector. A buffered sequence takes a word count and then programs that many words plus one, each at the address of its bus cycle. A two-cycle lock sequence is only acknowledged. Illegal codes raise an error bit and drop the device back to array reads. Reads return data one clock after the read strobe. Program and erase complete within a single clock.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset every array word reads as all ones, the status byte is 0x00 and the device is in array-read mode; read data appears on `bus_rdata` in the clock after the cycle where `bus_rd` is high.
- R2: In array-read mode, a command write of 0xFF or 0x00 leaves the device in array-read mode. A read returns the word at word index `bus_addr >> log2(DATA_W/8)`, modulo the array depth. `bus_rdata` holds its value in cycles without a read.
- R3: Command 0x20 immediately fills every word of the sector that holds the addressed word with all ones and sets status bit 7 (ready). Reads return the status byte until the next write.
- R4: Command 0x50 sets the status byte to 0x00 and returns the device to array-read mode.
- R5: Command 0x70 makes reads return the status byte, zero-extended, with bit 7 = ready and bit 4 = error. The next write is decoded as a fresh command.
- R6: Command 0x98 enters query mode. A read returns the table byte at index `bus_addr[7:0] >> log2(DATA_W/8)`. The table holds 0x51, 0x52, 0x59 at 0x10..0x12, 0x01 and 0x00 at 0x13..0x14, 0x31 and 0x00 at 0x15..0x16, and zero elsewhere. Indices at or beyond 0x52 read as zero. A write of 0xFF leaves query mode; any other write is ignored.
- R7: Command 0xE8 sets ready and makes reads return status. The next write gives a count N in its low byte. The following N+1 writes each store their full data word at their own address and set ready.
- R8: After the last buffered word, a write of 0xD0 sets ready and returns to array-read mode. Any other value sets status bit 4 and returns to array-read mode. The stored words are kept in both cases.
- R9: After command 0x60, a second write of 0xD0 or 0x01 sets ready and returns to array-read mode. A second write of 0xFF returns to array-read mode. Any other value sets status bit 4 and returns to array-read mode.
- R10: In the cycle after 0x20, a write of 0xFF restores array-read mode. A write of 0xD0 sets ready and leaves the device in status-read mode.
- R11: An unlisted first-cycle command code sets status bit 4, selects array-read mode and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data; the low byte is the command code |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The main stimulus is a table-driven sequence with distinct input patterns, each chosen to separate one source of read data from the others. Buffered programming stores 0xA5A5 and 0x5A5A at adjacent words. This exposes swapped addresses, words left unwritten or writes that spill into a neighbour. Query reads at several indices, including an address with bit 8 set, catch a wrong index shift or a wrong table entry. Erase, lock and bad-confirm sequences are followed by status reads whose values, 0x0080 against 0x0090 against 0x0010, tell ready apart from the error flag. Directed tests add a reset in the middle of a run, query indices near and past the table end, and read data held across idle cycles.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;

  localparam logic [7:0] MODE_ARRAY  = 8'h00;
  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] CMD_STAT    = 8'h70;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_BUFPGM  = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_LOCKALT = 8'h01;

  localparam logic [7:0] QTAB_LEN = 8'h52;
  localparam int unsigned ST_READY = 7;
  localparam int unsigned ST_ERR   = 4;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SECOND  = 2'd1,
    PH_DATA    = 2'd2,
    PH_CONFIRM = 2'd3
  } phase_e;

  function automatic logic reads_status(input logic [7:0] cmd);
    return (cmd == CMD_ERASE) || (cmd == CMD_CLRSTAT) || (cmd == CMD_LOCK) ||
           (cmd == CMD_STAT)  || (cmd == CMD_BUFPGM);
  endfunction

  function automatic logic known_first(input logic [7:0] code);
    return (code == MODE_ARRAY) || (code == CMD_READ)  || (code == CMD_ERASE) ||
           (code == CMD_CLRSTAT) || (code == CMD_LOCK) || (code == CMD_STAT) ||
           (code == CMD_QUERY)  || (code == CMD_BUFPGM);
  endfunction

endpackage

// File: rtl/flash_rst_sync.sv
`timescale 1ns/1ps
module flash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/flash_query_rom.sv
`timescale 1ns/1ps
module flash_query_rom
  import flash_pkg::*;
(
  input  logic [7:0] idx,
  output logic [7:0] qbyte
);
  always_comb begin
    qbyte = 8'h00;
    if (idx < QTAB_LEN) begin
      unique case (idx)
        8'h10:   qbyte = 8'h51;
        8'h11:   qbyte = 8'h52;
        8'h12:   qbyte = 8'h59;
        8'h13:   qbyte = 8'h01;
        8'h15:   qbyte = 8'h31;
        default: qbyte = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_byte,
  output phase_e      phase_q,
  output logic [7:0]  cmd_q,
  output logic [7:0]  status_q,
  output logic        erase_go,
  output logic        prog_go
);
  phase_e           phase_d;
  logic [7:0]       cmd_d;
  logic [7:0]       status_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d  = phase_q;
    cmd_d    = cmd_q;
    status_d = status_q;
    cnt_d    = cnt_q;
    erase_go = 1'b0;
    prog_go  = 1'b0;
    if (wr_en) begin
      unique case (phase_q)
        PH_IDLE: begin
          if ((wr_byte == MODE_ARRAY) || (wr_byte == CMD_READ)) begin
            phase_d = PH_IDLE;
            cmd_d   = MODE_ARRAY;
          end else if (wr_byte == CMD_ERASE) begin
            erase_go           = 1'b1;
            status_d[ST_READY] = 1'b1;
            phase_d            = PH_SECOND;
            cmd_d              = CMD_ERASE;
          end else if (wr_byte == CMD_CLRSTAT) begin
            status_d = 8'h00;
            phase_d  = PH_IDLE;
            cmd_d    = MODE_ARRAY;
          end else if (wr_byte == CMD_LOCK) begin
            phase_d = PH_SECOND;
            cmd_d   = CMD_LOCK;
          end else if (wr_byte == CMD_STAT) begin
            phase_d = PH_IDLE;
            cmd_d   = CMD_STAT;
          end else if (wr_byte == CMD_QUERY) begin
            phase_d = PH_SECOND;
            cmd_d   = CMD_QUERY;
          end else if (wr_byte == CMD_BUFPGM) begin
            status_d[ST_READY] = 1'b1;
            phase_d            = PH_SECOND;
            cmd_d              = CMD_BUFPGM;
          end else begin
            status_d[ST_ERR] = 1'b1;
            phase_d          = PH_IDLE;
            cmd_d            = MODE_ARRAY;
          end
        end
        PH_SECOND: begin
          if (cmd_q == CMD_ERASE) begin
            if (wr_byte == CMD_CONFIRM) begin
              status_d[ST_READY] = 1'b1;
              phase_d            = PH_IDLE;
              cmd_d              = CMD_STAT;
            end else if (wr_byte == CMD_READ) begin
              phase_d = PH_IDLE;
              cmd_d   = MODE_ARRAY;
            end else begin
              status_d[ST_ERR] = 1'b1;
              phase_d          = PH_IDLE;
              cmd_d            = MODE_ARRAY;
            end
          end else if (cmd_q == CMD_BUFPGM) begin
            cnt_d   = CNT_W'(wr_byte);
            phase_d = PH_DATA;
          end else if (cmd_q == CMD_LOCK) begin
            if ((wr_byte == CMD_CONFIRM) || (wr_byte == CMD_LOCKALT)) begin
              status_d[ST_READY] = 1'b1;
              phase_d            = PH_IDLE;
              cmd_d              = MODE_ARRAY;
            end else if (wr_byte == CMD_READ) begin
              phase_d = PH_IDLE;
              cmd_d   = MODE_ARRAY;
            end else begin
              status_d[ST_ERR] = 1'b1;
              phase_d          = PH_IDLE;
              cmd_d            = MODE_ARRAY;
            end
          end else if (cmd_q == CMD_QUERY) begin
            if (wr_byte == CMD_READ) begin
              phase_d = PH_IDLE;
              cmd_d   = MODE_ARRAY;
            end
          end else begin
            status_d[ST_ERR] = 1'b1;
            phase_d          = PH_IDLE;
            cmd_d            = MODE_ARRAY;
          end
        end
        PH_DATA: begin
          prog_go            = 1'b1;
          status_d[ST_READY] = 1'b1;
          if (cnt_q == '0) phase_d = PH_CONFIRM;
          else             cnt_d   = cnt_q - 1'b1;
        end
        PH_CONFIRM: begin
          if (wr_byte == CMD_CONFIRM) begin
            status_d[ST_READY] = 1'b1;
          end else begin
            status_d[ST_ERR] = 1'b1;
          end
          phase_d = PH_IDLE;
          cmd_d   = MODE_ARRAY;
        end
        default: begin
          phase_d = PH_IDLE;
          cmd_d   = MODE_ARRAY;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cmd_q    <= MODE_ARRAY;
      status_q <= 8'h00;
      cnt_q    <= '0;
    end else begin
      phase_q  <= phase_d;
      cmd_q    <= cmd_d;
      status_q <= status_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_PROG_NEEDS_BUFCMD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_DATA) || (phase_q == PH_CONFIRM)) |-> (cmd_q == CMD_BUFPGM)); // R7
  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (phase_q == PH_IDLE) && (wr_byte == CMD_CLRSTAT))
      |=> ((status_q == 8'h00) && (cmd_q == MODE_ARRAY))); // R4
  AST_ERASE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (status_q[ST_READY] && (cmd_q == CMD_ERASE))); // R3
  AST_SECOND_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (phase_q == PH_SECOND) && ((cmd_q == CMD_ERASE) || (cmd_q == CMD_QUERY))
       && (wr_byte == CMD_READ))
      |=> ((phase_q == PH_IDLE) && (cmd_q == MODE_ARRAY))); // R10
  AST_BAD_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (phase_q == PH_IDLE) && !known_first(wr_byte))
      |=> (status_q[ST_ERR] && (cmd_q == MODE_ARRAY) && (phase_q == PH_IDLE))); // R11
  AST_LOCK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (phase_q == PH_SECOND) && (cmd_q == CMD_LOCK) && (wr_byte == CMD_LOCKALT))
      |=> (status_q[ST_READY] && (cmd_q == MODE_ARRAY))); // R9
endmodule

// File: rtl/flash_array.sv
`timescale 1ns/1ps
module flash_array #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SECT_WORDS = 16,
  parameter int unsigned NUM_SECT   = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        erase_go,
  input  logic                                        prog_go,
  input  logic [$clog2(SECT_WORDS*NUM_SECT)-1:0]      idx,
  input  logic [DATA_W-1:0]                           wdata,
  output logic [DATA_W-1:0]                           rd_word
);
  localparam int unsigned DEPTH = SECT_WORDS * NUM_SECT;
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned SEC_W = $clog2(SECT_WORDS);

  logic [DATA_W-1:0] words [DEPTH];
  logic [IDX_W-1:0]  sec_of_idx;
  logic [IDX_W-1:0]  sec_base;

  assign sec_of_idx = idx >> SEC_W;
  assign sec_base   = sec_of_idx << SEC_W;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [IDX_W-1:0] WIDX = IDX_W'(w);
    localparam logic [IDX_W-1:0] WSEC = IDX_W'(w >> SEC_W);
    logic [DATA_W-1:0] word_q;
    logic              wr_hit, er_hit;

    assign wr_hit = prog_go && (idx == WIDX);
    assign er_hit = erase_go && (sec_of_idx == WSEC);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= '1;
      else if (wr_hit) word_q <= wdata;
      else if (er_hit) word_q <= '1;
    end

    assign words[w] = word_q;
  end

  assign rd_word = words[idx];

  AST_ERASE_FILLS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (words[$past(sec_base)] == '1)); // R3
  AST_PROG_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> (words[$past(idx)] == $past(wdata))); // R7
endmodule

// File: rtl/flash_cmd_if.sv
`timescale 1ns/1ps
module flash_cmd_if
  import flash_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SECT_WORDS = 16,
  parameter int unsigned NUM_SECT   = 4,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned BSH   = $clog2(BYTES);
  localparam int unsigned DEPTH = SECT_WORDS * NUM_SECT;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic              srst_n;
  phase_e            phase_q;
  logic [7:0]        cmd_q, status_q;
  logic              erase_go, prog_go;
  logic [IDX_W-1:0]  word_idx;
  logic [7:0]        q_idx, q_byte;
  logic [DATA_W-1:0] arr_word, rd_next;
  logic              addr_unused;

  assign word_idx    = bus_addr[BSH +: IDX_W];
  assign q_idx       = bus_addr[7:0] >> BSH;
  assign addr_unused = ^bus_addr;

  flash_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  flash_cmd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (bus_wr),
    .wr_byte  (bus_wdata[7:0]),
    .phase_q  (phase_q),
    .cmd_q    (cmd_q),
    .status_q (status_q),
    .erase_go (erase_go),
    .prog_go  (prog_go)
  );

  flash_array #(
    .DATA_W     (DATA_W),
    .SECT_WORDS (SECT_WORDS),
    .NUM_SECT   (NUM_SECT)
  ) u_arr (
    .clk      (clk),
    .rst_n    (srst_n),
    .erase_go (erase_go),
    .prog_go  (prog_go),
    .idx      (word_idx),
    .wdata    (bus_wdata),
    .rd_word  (arr_word)
  );

  flash_query_rom u_rom (
    .idx   (q_idx),
    .qbyte (q_byte)
  );

  always_comb begin
    if (cmd_q == CMD_QUERY)       rd_next = DATA_W'(q_byte);
    else if (reads_status(cmd_q)) rd_next = DATA_W'(status_q);
    else                          rd_next = arr_word;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  AST_QUERY_PAST_END: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && (cmd_q == CMD_QUERY) && (q_idx >= QTAB_LEN)) |=> (bus_rdata == '0)); // R6
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && (cmd_q == CMD_STAT)) |=> (bus_rdata == DATA_W'($past(status_q)))); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_rd |=> $stable(bus_rdata)); // R2
  AST_PHASE_MODE: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == PH_IDLE) |-> ((cmd_q == MODE_ARRAY) || (cmd_q == CMD_STAT))); // R1
endmodule

// File: tb/flash_cmd_if_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_if_tb_top;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned NVEC   = 64;
  localparam int unsigned WDOG   = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_if dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata)
  );

  // {op(0 write, 1 read-check), byte address, data or expected, requirement}
  localparam logic [30:0] VEC [NVEC] = '{
    {2'd1, 9'h000, 16'hFFFF, 4'd1},   // R1 reset array
    {2'd0, 9'h000, 16'h00E8, 4'd7},   // R7 buffer program
    {2'd1, 9'h000, 16'h0080, 4'd7},   // R7 status during sequence
    {2'd0, 9'h000, 16'h0001, 4'd7},   // R7 count N=1
    {2'd0, 9'h020, 16'hA5A5, 4'd7},
    {2'd0, 9'h022, 16'h5A5A, 4'd7},
    {2'd0, 9'h000, 16'h00D0, 4'd8},   // R8 confirm
    {2'd1, 9'h020, 16'hA5A5, 4'd8},
    {2'd1, 9'h022, 16'h5A5A, 4'd7},
    {2'd1, 9'h024, 16'hFFFF, 4'd7},   // R7 neighbour untouched
    {2'd0, 9'h000, 16'h0070, 4'd5},   // R5 status read
    {2'd1, 9'h010, 16'h0080, 4'd5},
    {2'd0, 9'h000, 16'h0050, 4'd4},   // R4 clear
    {2'd1, 9'h020, 16'hA5A5, 4'd4},
    {2'd0, 9'h000, 16'h0070, 4'd4},
    {2'd1, 9'h000, 16'h0000, 4'd4},
    {2'd0, 9'h000, 16'h00FF, 4'd2},   // R2 read array
    {2'd1, 9'h022, 16'h5A5A, 4'd2},
    {2'd0, 9'h000, 16'h0098, 4'd6},   // R6 query
    {2'd1, 9'h020, 16'h0051, 4'd6},
    {2'd1, 9'h022, 16'h0052, 4'd6},
    {2'd1, 9'h024, 16'h0059, 4'd6},
    {2'd1, 9'h026, 16'h0001, 4'd6},
    {2'd1, 9'h02A, 16'h0031, 4'd6},
    {2'd1, 9'h032, 16'h0000, 4'd6},
    {2'd1, 9'h120, 16'h0051, 4'd6},   // R6 bit 8 outside index
    {2'd0, 9'h000, 16'h0055, 4'd6},   // R6 ignored write
    {2'd1, 9'h020, 16'h0051, 4'd6},
    {2'd0, 9'h000, 16'h00FF, 4'd6},
    {2'd1, 9'h020, 16'hA5A5, 4'd6},
    {2'd0, 9'h03E, 16'h0020, 4'd3},   // R3 erase sector 1
    {2'd1, 9'h020, 16'h0080, 4'd3},
    {2'd0, 9'h000, 16'h00D0, 4'd10},  // R10 erase confirm
    {2'd1, 9'h020, 16'h0080, 4'd10},
    {2'd0, 9'h000, 16'h00FF, 4'd3},
    {2'd1, 9'h020, 16'hFFFF, 4'd3},
    {2'd1, 9'h022, 16'hFFFF, 4'd3},
    {2'd0, 9'h000, 16'h0020, 4'd10},  // R10 erase abort
    {2'd0, 9'h000, 16'h00FF, 4'd10},
    {2'd1, 9'h000, 16'hFFFF, 4'd10},
    {2'd0, 9'h000, 16'h0060, 4'd9},   // R9 lock
    {2'd1, 9'h000, 16'h0080, 4'd9},
    {2'd0, 9'h000, 16'h0001, 4'd9},
    {2'd1, 9'h000, 16'hFFFF, 4'd9},
    {2'd0, 9'h000, 16'h0060, 4'd9},
    {2'd0, 9'h000, 16'h0077, 4'd9},   // R9 bad second value
    {2'd0, 9'h000, 16'h0070, 4'd9},
    {2'd1, 9'h000, 16'h0090, 4'd9},
    {2'd0, 9'h000, 16'h0050, 4'd11},  // R11 illegal code
    {2'd0, 9'h000, 16'h0033, 4'd11},
    {2'd1, 9'h020, 16'hFFFF, 4'd11},
    {2'd0, 9'h000, 16'h0070, 4'd11},
    {2'd1, 9'h000, 16'h0010, 4'd11},
    {2'd0, 9'h000, 16'h0050, 4'd8},   // R8 bad confirm
    {2'd0, 9'h000, 16'h00E8, 4'd8},
    {2'd0, 9'h000, 16'h0000, 4'd8},
    {2'd0, 9'h040, 16'h1234, 4'd8},
    {2'd0, 9'h000, 16'h0042, 4'd8},
    {2'd1, 9'h040, 16'h1234, 4'd8},
    {2'd0, 9'h000, 16'h0070, 4'd8},
    {2'd1, 9'h000, 16'h0090, 4'd8},
    {2'd0, 9'h000, 16'h0050, 4'd2},   // R2 code 0x00
    {2'd0, 9'h000, 16'h0000, 4'd2},
    {2'd1, 9'h040, 16'h1234, 4'd2}
  };

  task automatic check(input int req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                          input int req);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    apply_reset();
    // R1 reset state of read data register
    check(1, bus_rdata, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][30:29] == 2'd0) bus_write(VEC[i][28:20], VEC[i][19:4]);
      else                       bus_read(VEC[i][28:20], VEC[i][19:4], int'(VEC[i][3:0]));
    end

    // R6 indices at and past the table end
    bus_write(9'h000, 16'h0098);
    bus_read(9'h0A2, 16'h0000, 6);   // index 0x51
    bus_read(9'h0A4, 16'h0000, 6);   // index 0x52
    bus_read(9'h0FE, 16'h0000, 6);   // index 0x7F
    bus_write(9'h000, 16'h00FF);

    // R1 reset in mid-run: array back to ones, status cleared, array mode
    bus_write(9'h000, 16'h0070);
    apply_reset();
    bus_read(9'h040, 16'hFFFF, 1);
    bus_write(9'h000, 16'h0070);
    bus_read(9'h000, 16'h0000, 1);
    bus_write(9'h000, 16'h00FF);

    // R2 read data holds across idle cycles; R7 single-word program (N=0)
    bus_write(9'h000, 16'h00E8);
    bus_write(9'h000, 16'h0000);
    bus_write(9'h002, 16'hBEEF);
    bus_write(9'h000, 16'h00D0);
    bus_read(9'h002, 16'hBEEF, 7);
    bus_addr = 9'h004;
    repeat (3) @(negedge clk);
    check(2, bus_rdata, 16'hBEEF);
    bus_read(9'h004, 16'hFFFF, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule